// File: doc/BRIEF.md
# Keyed System Control Register File

This block is the control and identification register file of a processor module. A host reaches it over a 32-bit, word-addressed register bus that has separate read and write strobes. Read data is combinational: it is valid in the same cycle as the read strobe and is zero when no read is in progress. Writes take effect at the clock edge that samples the write strobe.

The block contains constant identification and status words and two oscillator setting registers. The oscillator registers accept writes only while a 16-bit unlock key is held in the lock register. The block also has a control word that drives an indicator LED, a boot-memory remap level and a board-reset request pulse. It holds SDRAM and init settings, and two flag registers that are each changed through a pair of set and clear words. A one-bit software interrupt source has separately maskable IRQ and FIQ outputs. A read-only window returns serial-presence-detect bytes from a small table; one entry of that table, and a field of the SDRAM word, depend on the installed memory size. Accesses to addresses outside the map read as zero and raise an error pulse.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, the registers read as follows: word 0 reads 0x411A3001, word 1 reads 0, word 4 reads 0x00100000, word 2 reads 0x01000048, word 7 reads 0x0007FEFF, word 9 reads 0x00000112, word 3 reads 0, and word 8 reads 0x00011122 with the size code in bits 4:2.
- R2: A write to word 5 stores only data bits 15:0. A read of word 5 returns the stored key, and bit 16 is set exactly when the stored key equals 0xA05F.
- R3: A write to word 2 or word 7 replaces the register only while the stored key equals 0xA05F. Otherwise the register keeps its value.
- R4: A write to word 12 ORs the data into the flags, and a write to word 13 clears the flag bits that are 1 in the data. Words 14 and 15 do the same for the non-volatile flags. Words 12 and 14 read the current values, and words 13 and 15 read 0.
- R5: Words 18 and 26 set IRQ and FIQ enable bits, and words 19 and 27 clear them. Words 16 and 24 read level AND enable, words 17 and 25 read the raw level, and words 18 and 26 read the enables. irq_o and fiq_o are high exactly when level AND the matching enable is nonzero.
- R6: Only level bit 0 exists. A write to word 20 sets it when data bit 0 is 1. A write to word 21 clears it when data bit 0 is 1. Word 20 reads level bit 0.
- R7: Words 64 to 95 read one presence-detect byte each, zero-extended, indexed by word minus 64. Entries 0 to 6 are 128, 8, 4, 11, 9, 1 and 64. Entry 31 is 2 shifted left by the size code. Every other entry reads 0. Words 96 to 127 read 0.
- R8: A write to word 3 stores the data with bit 3 forced to 0. led_o follows stored bit 0 and remap_o follows stored bit 2. board_rst_o pulses for one cycle after a write whose bit 3 is 1.
- R9: The size code is 0 below 32 MB, and 1, 2, 3 and 4 from 32, 64, 128 and 256 MB upward. It stays in SDRAM bits 4:2 across writes to word 8, which set all other bits. A write to word 9 replaces the init word.
- R10: Words 32 to 35 read 0 and ignore writes. Writes to words 0, 1, 4, 16, 17, 24 and 25 and to the presence-detect window are ignored. Any other word outside the map reads 0, and a read or write of it makes err_o pulse for one cycle after the access.
- R11: bus_rdata is 0 in any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| irq_o | output | 1 | Masked interrupt, IRQ path |
| fiq_o | output | 1 | Masked interrupt, FIQ path |
| led_o | output | 1 | Indicator LED level |
| remap_o | output | 1 | Boot-memory remap level |
| board_rst_o | output | 1 | One-cycle board reset request |
| err_o | output | 1 | One-cycle unmapped-access pulse |

## Verification
On every cycle, the assertions check that the oscillator registers hold still through a write made while locked. They also check that the unlocked flag in a lock readback agrees with the key beside it, and that a status read agrees with the IRQ and FIQ pins. They check that reset and error pulses only follow an access that could cause them, and that read data is quiet without a strobe. The bench scenarios are what show the bitwise set and clear arithmetic of the flags, the presence-detect contents, the sticky size field in the SDRAM word, and that read-only and voltage words really ignore writes.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned DW = 32;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [31:0] ID_WORD    = 32'h411A3001;
  localparam logic [31:0] STAT_WORD  = 32'h00100000;
  localparam logic [31:0] OSC_RST    = 32'h01000048;
  localparam logic [31:0] AUX_RST    = 32'h0007FEFF;
  localparam logic [31:0] SDRAM_BASE = 32'h00011122;
  localparam logic [31:0] INIT_RST   = 32'h00000112;
  localparam logic [31:0] SIZE_MASK  = 32'h0000001C;

  typedef enum logic [4:0] {
    SEL_ID, SEL_ZERO, SEL_OSC, SEL_CTRL, SEL_STAT, SEL_LOCK, SEL_AUX,
    SEL_SDRAM, SEL_INIT, SEL_FLAG_S, SEL_FLAG_C, SEL_NV_S, SEL_NV_C,
    SEL_IRQ_ST, SEL_IRQ_RAW, SEL_IEN_S, SEL_IEN_C, SEL_SOFT_S, SEL_SOFT_C,
    SEL_FIQ_ST, SEL_FIQ_RAW, SEL_FEN_S, SEL_FEN_C, SEL_VOLT, SEL_SPD,
    SEL_SPD_HI, SEL_BAD
  } sel_e;

  function automatic logic [2:0] size_code(input int unsigned mb);
    if (mb >= 256)      return 3'd4;
    else if (mb >= 128) return 3'd3;
    else if (mb >= 64)  return 3'd2;
    else if (mb >= 32)  return 3'd1;
    else                return 3'd0;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic [AW-1:0] addr,
  output sel_e          sel
);
  logic       in_range;
  logic [6:0] w;

  assign in_range = ((addr >> 7) == '0);
  assign w        = addr[6:0];

  always_comb begin
    sel = SEL_BAD;
    if (in_range) begin
      if (w >= 7'd96)      sel = SEL_SPD_HI;
      else if (w >= 7'd64) sel = SEL_SPD;
      else if (w >= 7'd32 && w <= 7'd35) sel = SEL_VOLT;
      else begin
        case (w)
          7'd0:  sel = SEL_ID;
          7'd1:  sel = SEL_ZERO;
          7'd2:  sel = SEL_OSC;
          7'd3:  sel = SEL_CTRL;
          7'd4:  sel = SEL_STAT;
          7'd5:  sel = SEL_LOCK;
          7'd7:  sel = SEL_AUX;
          7'd8:  sel = SEL_SDRAM;
          7'd9:  sel = SEL_INIT;
          7'd12: sel = SEL_FLAG_S;
          7'd13: sel = SEL_FLAG_C;
          7'd14: sel = SEL_NV_S;
          7'd15: sel = SEL_NV_C;
          7'd16: sel = SEL_IRQ_ST;
          7'd17: sel = SEL_IRQ_RAW;
          7'd18: sel = SEL_IEN_S;
          7'd19: sel = SEL_IEN_C;
          7'd20: sel = SEL_SOFT_S;
          7'd21: sel = SEL_SOFT_C;
          7'd24: sel = SEL_FIQ_ST;
          7'd25: sel = SEL_FIQ_RAW;
          7'd26: sel = SEL_FEN_S;
          7'd27: sel = SEL_FEN_C;
          default: sel = SEL_BAD;
        endcase
      end
    end
  end
endmodule

// File: rtl/sysctl_spd_rom.sv
module sysctl_spd_rom
  import sysctl_pkg::*;
#(
  parameter int unsigned MEM_MB = 128
) (
  input  logic [4:0] idx,
  output logic [7:0] byte_o
);
  localparam logic [2:0] SZ = size_code(MEM_MB);
  localparam logic [7:0] DENSITY = 8'd2 << SZ;

  always_comb begin
    case (idx)
      5'd0:  byte_o = 8'd128;
      5'd1:  byte_o = 8'd8;
      5'd2:  byte_o = 8'd4;
      5'd3:  byte_o = 8'd11;
      5'd4:  byte_o = 8'd9;
      5'd5:  byte_o = 8'd1;
      5'd6:  byte_o = 8'd64;
      5'd31: byte_o = DENSITY;
      default: byte_o = 8'd0;
    endcase
  end
endmodule

// File: rtl/sysctl_intc.sv
module sysctl_intc
  import sysctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ien_set,
  input  logic          ien_clr,
  input  logic          fen_set,
  input  logic          fen_clr,
  input  logic          soft_set,
  input  logic          soft_clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] level,
  output logic [DW-1:0] ien,
  output logic [DW-1:0] fen,
  output logic          irq_o,
  output logic          fiq_o
);
  logic [DW-1:0] ien_q, ien_d, fen_q, fen_d;
  logic          soft_q, soft_d;

  always_comb begin
    ien_d  = ien_q;
    fen_d  = fen_q;
    soft_d = soft_q;
    if (ien_set) ien_d = ien_q | wdata;
    if (ien_clr) ien_d = ien_q & ~wdata;
    if (fen_set) fen_d = fen_q | wdata;
    if (fen_clr) fen_d = fen_q & ~wdata;
    if (soft_set && wdata[0]) soft_d = 1'b1;
    if (soft_clr && wdata[0]) soft_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      fen_q  <= '0;
      soft_q <= 1'b0;
    end else begin
      ien_q  <= ien_d;
      fen_q  <= fen_d;
      soft_q <= soft_d;
    end
  end

  assign level = {{(DW-1){1'b0}}, soft_q};
  assign ien   = ien_q;
  assign fen   = fen_q;
  assign irq_o = |(level & ien_q);
  assign fiq_o = |(level & fen_q);
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int unsigned AW     = 7,
  parameter int unsigned MEM_MB = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq_o,
  output logic          fiq_o,
  output logic          led_o,
  output logic          remap_o,
  output logic          board_rst_o,
  output logic          err_o
);
  localparam logic [31:0] SZ_BITS   = {27'd0, size_code(MEM_MB), 2'b00};
  localparam logic [31:0] SDRAM_RST = SDRAM_BASE | SZ_BITS;

  sel_e          sel;
  logic [7:0]    spd_byte;
  logic [DW-1:0] level, ien, fen;
  logic          wr_ok;

  logic [31:0] osc_q, osc_d, aux_q, aux_d, ctrl_q, ctrl_d;
  logic [31:0] sdram_q, sdram_d, init_q, init_d;
  logic [31:0] flags_q, flags_d, nv_q, nv_d;
  logic [15:0] lock_q, lock_d;
  logic        rst_req_q, rst_req_d, err_q, err_d;

  sysctl_decode #(.AW(AW)) u_dec (.addr(bus_addr), .sel(sel));

  sysctl_spd_rom #(.MEM_MB(MEM_MB)) u_spd (.idx(bus_addr[4:0]), .byte_o(spd_byte));

  sysctl_intc u_intc (
    .clk      (clk),
    .rst_n    (rst_n),
    .ien_set  (bus_wr && sel == SEL_IEN_S),
    .ien_clr  (bus_wr && sel == SEL_IEN_C),
    .fen_set  (bus_wr && sel == SEL_FEN_S),
    .fen_clr  (bus_wr && sel == SEL_FEN_C),
    .soft_set (bus_wr && sel == SEL_SOFT_S),
    .soft_clr (bus_wr && sel == SEL_SOFT_C),
    .wdata    (bus_wdata),
    .level    (level),
    .ien      (ien),
    .fen      (fen),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o)
  );

  assign wr_ok = (lock_q == UNLOCK_KEY);

  always_comb begin
    osc_d     = osc_q;
    aux_d     = aux_q;
    ctrl_d    = ctrl_q;
    sdram_d   = sdram_q;
    init_d    = init_q;
    flags_d   = flags_q;
    nv_d      = nv_q;
    lock_d    = lock_q;
    rst_req_d = 1'b0;
    err_d     = (bus_rd || bus_wr) && (sel == SEL_BAD);
    if (bus_wr) begin
      case (sel)
        SEL_OSC:    if (wr_ok) osc_d = bus_wdata;
        SEL_AUX:    if (wr_ok) aux_d = bus_wdata;
        SEL_LOCK:   lock_d = bus_wdata[15:0];
        SEL_CTRL: begin
          ctrl_d    = bus_wdata & ~32'h8;
          rst_req_d = bus_wdata[3];
        end
        SEL_SDRAM:  sdram_d = (bus_wdata & ~SIZE_MASK) | SZ_BITS;
        SEL_INIT:   init_d  = bus_wdata;
        SEL_FLAG_S: flags_d = flags_q | bus_wdata;
        SEL_FLAG_C: flags_d = flags_q & ~bus_wdata;
        SEL_NV_S:   nv_d    = nv_q | bus_wdata;
        SEL_NV_C:   nv_d    = nv_q & ~bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q     <= OSC_RST;
      aux_q     <= AUX_RST;
      ctrl_q    <= '0;
      sdram_q   <= SDRAM_RST;
      init_q    <= INIT_RST;
      flags_q   <= '0;
      nv_q      <= '0;
      lock_q    <= '0;
      rst_req_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      osc_q     <= osc_d;
      aux_q     <= aux_d;
      ctrl_q    <= ctrl_d;
      sdram_q   <= sdram_d;
      init_q    <= init_d;
      flags_q   <= flags_d;
      nv_q      <= nv_d;
      lock_q    <= lock_d;
      rst_req_q <= rst_req_d;
      err_q     <= err_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_ID:      bus_rdata = ID_WORD;
        SEL_STAT:    bus_rdata = STAT_WORD;
        SEL_OSC:     bus_rdata = osc_q;
        SEL_AUX:     bus_rdata = aux_q;
        SEL_CTRL:    bus_rdata = ctrl_q;
        SEL_LOCK:    bus_rdata = {15'd0, wr_ok, lock_q};
        SEL_SDRAM:   bus_rdata = sdram_q;
        SEL_INIT:    bus_rdata = init_q;
        SEL_FLAG_S:  bus_rdata = flags_q;
        SEL_NV_S:    bus_rdata = nv_q;
        SEL_IRQ_ST:  bus_rdata = level & ien;
        SEL_IRQ_RAW: bus_rdata = level;
        SEL_IEN_S:   bus_rdata = ien;
        SEL_FIQ_ST:  bus_rdata = level & fen;
        SEL_FIQ_RAW: bus_rdata = level;
        SEL_FEN_S:   bus_rdata = fen;
        SEL_SOFT_S:  bus_rdata = {31'd0, level[0]};
        SEL_SPD:     bus_rdata = {24'd0, spd_byte};
        default:     bus_rdata = '0;
      endcase
    end
  end

  assign led_o       = ctrl_q[0];
  assign remap_o     = ctrl_q[2];
  assign board_rst_o = rst_req_q;
  assign err_o       = err_q;
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int unsigned AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          irq_o,
  input logic          fiq_o,
  input logic          board_rst_o,
  input logic          err_o,
  input logic [31:0]   osc_q,
  input logic [31:0]   aux_q,
  input logic [15:0]   lock_q
);
  AST_LOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(5)) |-> (bus_rdata[16] == (bus_rdata[15:0] == 16'hA05F))); // R2

  AST_OSC_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(2) && lock_q != 16'hA05F) |=> $stable(osc_q)); // R3

  AST_AUX_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(7) && lock_q != 16'hA05F) |=> $stable(aux_q)); // R3

  AST_IRQ_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(16)) |-> ((bus_rdata != 0) == irq_o)); // R5

  AST_FIQ_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(24)) |-> ((bus_rdata != 0) == fiq_o)); // R5

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(board_rst_o) |-> $past(bus_wr && bus_addr == AW'(3) && bus_wdata[3])); // R8

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(bus_rd || bus_wr)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 32'd0)); // R11
endmodule

bind sysctl_regfile sysctl_regfile_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .board_rst_o (board_rst_o),
  .err_o       (err_o),
  .osc_q       (osc_q),
  .aux_q       (aux_q),
  .lock_q      (lock_q)
);

// File: tb/tb_sysctl_regfile.sv
module tb_sysctl_regfile;
  localparam int AW = 7;

  logic          clk, rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_rd, bus_wr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          irq_o, fiq_o, led_o, remap_o, board_rst_o, err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural model state (memory size 128 MB -> size code 3)
  logic [31:0] m_osc, m_aux, m_ctrl, m_sdram, m_init, m_flags, m_nv, m_ien, m_fen;
  logic [15:0] m_lock;
  logic        m_lvl, e_rst, e_err;

  sysctl_regfile dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o),
    .led_o(led_o), .remap_o(remap_o), .board_rst_o(board_rst_o), .err_o(err_o)
  );

  initial begin
    clk = 0;
    forever #10 clk = ~clk;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] spd_exp(input int i);
    case (i)
      0: return 128; 1: return 8; 2: return 4; 3: return 11;
      4: return 9;   5: return 1; 6: return 64; 31: return 32'd2 << 3;
      default: return 0;
    endcase
  endfunction

  function automatic bit mapped(input int a);
    if (a >= 64 && a <= 127) return 1;
    if (a >= 32 && a <= 35) return 1;
    if (a <= 5 || a == 7 || a == 8 || a == 9) return 1;
    if (a >= 12 && a <= 21) return 1;
    if (a >= 24 && a <= 27) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] model_read(input int a);
    if (a >= 64 && a < 96) return spd_exp(a - 64);
    case (a)
      0:  return 32'h411A3001;
      4:  return 32'h00100000;
      2:  return m_osc;
      7:  return m_aux;
      3:  return m_ctrl;
      5:  return (m_lock == 16'hA05F) ? 32'h0001A05F : {16'd0, m_lock};
      8:  return m_sdram;
      9:  return m_init;
      12: return m_flags;
      14: return m_nv;
      16: return {31'd0, m_lvl & m_ien[0]};
      17: return {31'd0, m_lvl};
      18: return m_ien;
      20: return {31'd0, m_lvl};
      24: return {31'd0, m_lvl & m_fen[0]};
      25: return {31'd0, m_lvl};
      26: return m_fen;
      default: return 0;
    endcase
  endfunction

  task automatic model_write(input int a, input logic [31:0] d);
    case (a)
      2:  if (m_lock == 16'hA05F) m_osc = d;
      7:  if (m_lock == 16'hA05F) m_aux = d;
      5:  m_lock = d[15:0];
      3:  begin m_ctrl = d & 32'hFFFF_FFF7; e_rst = d[3]; end
      8:  m_sdram = (d & 32'hFFFF_FFE3) | 32'h0000000C;
      9:  m_init = d;
      12: m_flags = m_flags | d;
      13: m_flags = m_flags & ~d;
      14: m_nv = m_nv | d;
      15: m_nv = m_nv & ~d;
      18: m_ien = m_ien | d;
      19: m_ien = m_ien & ~d;
      26: m_fen = m_fen | d;
      27: m_fen = m_fen & ~d;
      20: if (d[0]) m_lvl = 1'b1;
      21: if (d[0]) m_lvl = 1'b0;
      default: ;
    endcase
  endtask

  // one bus cycle, entered and left at a falling edge
  task automatic step(input bit rd, input bit wr, input int a, input logic [31:0] d, input string req);
    bus_rd = rd; bus_wr = wr; bus_addr = AW'(a); bus_wdata = d;
    #2;
    chk(req, $sformatf("rdata word %0d", a), bus_rdata, rd ? model_read(a) : 32'd0);
    chk("R5", "irq_o", {31'd0, irq_o}, {31'd0, m_lvl & m_ien[0]});
    chk("R5", "fiq_o", {31'd0, fiq_o}, {31'd0, m_lvl & m_fen[0]});
    chk("R8", "led_o", {31'd0, led_o}, {31'd0, m_ctrl[0]});
    chk("R8", "remap_o", {31'd0, remap_o}, {31'd0, m_ctrl[2]});
    chk("R8", "board_rst_o", {31'd0, board_rst_o}, {31'd0, e_rst});
    chk("R10", "err_o", {31'd0, err_o}, {31'd0, e_err});
    @(posedge clk);
    e_rst = 1'b0;
    e_err = (rd || wr) && !mapped(a);
    if (wr) model_write(a, d);
    @(negedge clk);
  endtask

  task automatic rd_(input int a, input string req); step(1, 0, a, 32'd0, req); endtask
  task automatic wr_(input int a, input logic [31:0] d, input string req); step(0, 1, a, d, req); endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_ctrl = 0; m_sdram = 32'h0001112E;
    m_init = 32'h00000112; m_flags = 0; m_nv = 0; m_ien = 0; m_fen = 0; m_lock = 0;
    m_lvl = 0; e_rst = 0; e_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_(0, "R1"); rd_(1, "R1"); rd_(4, "R1"); rd_(2, "R1"); rd_(7, "R1");
    rd_(8, "R1"); rd_(9, "R1"); rd_(3, "R1"); rd_(5, "R2");

    // R3 locked writes ignored
    wr_(2, 32'hDEADBEEF, "R3"); rd_(2, "R3");
    wr_(7, 32'h12345678, "R3"); rd_(7, "R3");
    // R2 key storage and flag
    wr_(5, 32'h1234A05F, "R2"); rd_(5, "R2");
    wr_(2, 32'hDEADBEEF, "R3"); rd_(2, "R3");
    wr_(7, 32'hCAFE0001, "R3"); rd_(7, "R3");
    wr_(5, 32'hFFFFA05E, "R2"); rd_(5, "R2");
    wr_(2, 32'h0, "R3"); rd_(2, "R3");

    // R4 flags
    wr_(12, 32'h0000F0F0, "R4"); wr_(12, 32'h00000F00, "R4"); rd_(12, "R4");
    wr_(13, 32'h000000F0, "R4"); rd_(12, "R4"); rd_(13, "R4");
    wr_(14, 32'h80000001, "R4"); wr_(15, 32'h00000001, "R4"); rd_(14, "R4"); rd_(15, "R4");

    // R9 sdram size field and init
    wr_(8, 32'hFFFFFFFF, "R9"); rd_(8, "R9");
    wr_(8, 32'h00000000, "R9"); rd_(8, "R9");
    wr_(9, 32'hA5A5A5A5, "R9"); rd_(9, "R9");

    // R5 R6 interrupt
    wr_(18, 32'h00000003, "R5"); rd_(18, "R5"); rd_(16, "R5");
    wr_(20, 32'h00000002, "R6"); rd_(20, "R6");
    wr_(20, 32'h00000001, "R6"); rd_(20, "R6"); rd_(16, "R5"); rd_(17, "R5");
    wr_(26, 32'h00000001, "R5"); rd_(24, "R5"); rd_(25, "R5"); rd_(26, "R5");
    wr_(19, 32'h00000001, "R5"); rd_(16, "R5"); rd_(18, "R5");
    wr_(27, 32'hFFFFFFFF, "R5"); rd_(24, "R5");
    wr_(21, 32'h00000000, "R6"); rd_(20, "R6");
    wr_(21, 32'h00000001, "R6"); rd_(20, "R6"); rd_(21, "R6");

    // R8 control
    wr_(3, 32'h0000000D, "R8"); rd_(3, "R8");
    wr_(3, 32'h00000004, "R8"); rd_(3, "R8");
    wr_(3, 32'h00000000, "R8"); rd_(3, "R8");

    // R7 presence-detect window
    rd_(64, "R7"); rd_(66, "R7"); rd_(70, "R7"); rd_(71, "R7"); rd_(95, "R7");
    rd_(96, "R7"); rd_(127, "R7");

    // R10 voltage, read-only, unmapped
    wr_(33, 32'hFFFFFFFF, "R10"); rd_(33, "R10");
    wr_(0, 32'h0, "R10"); rd_(0, "R10");
    wr_(17, 32'hFFFFFFFF, "R10"); rd_(17, "R10");
    wr_(64, 32'h0, "R10"); rd_(64, "R10");
    rd_(6, "R10"); rd_(10, "R10");
    wr_(40, 32'hFFFFFFFF, "R10"); rd_(12, "R10");

    // R11 idle
    step(0, 0, 0, 32'd0, "R11");
    step(0, 0, 5, 32'd0, "R11");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule